// File: doc/BRIEF.md
# Chip-Level Prefetch Aggressiveness Governor

This block sits above the local prefetch controllers of four cores and decides, once per sampling interval, how far each core's prefetch aggressiveness level may move. The level is a single per-core setting that scales prefetch distance and prefetch degree together. It runs from 1 (least aggressive) to 5 (most aggressive).

During each interval the block counts three kinds of events for every core: prefetches issued, issued prefetches that proved useful, and accesses to the shared last-level cache. When the interval closes, each count is folded into a running value that halves the old value and adds the fresh count. The running values are then judged high or low against programmable thresholds. A fixed rule table combines the per-core accuracy, the per-core prefetch rate and the shared-cache load. The table either forces the level down one step, blocks an upward step, or lets the local controller's proposal through unchanged. All four levels are written together, and a one-cycle valid strobe accompanies them.

The local controller is represented only by its proposed step. It is sampled in the last cycle of each interval.

Top module: `gpc_aggr_override`

## Requirements
- R1: While reset is asserted, and afterwards until the first update, every core's level reads 3 (3-bit binary field per core, core c at bits [3c+2:3c]) and the valid strobe is 0.
- R2: At each interval end, every running value becomes floor(previous running value / 2) plus the number of events seen in the interval just ended. The interval's event counts then restart from zero.
- R3: A core with low accuracy, high prefetch rate and high cache load steps down one level, whatever it proposed.
- R4: A core with high accuracy, high prefetch rate and high cache load cannot step up. A proposed up becomes hold, and down or hold pass through.
- R5: A core with low accuracy, high prefetch rate and low cache load cannot step up. Down or hold pass through.
- R6: In every other combination the proposal is applied as given. The step code is 2 bits per core at [2c+1:2c]: 01 up, 10 down, 00 and 11 hold.
- R7: Levels saturate: a step down at level 1 and a step up at level 5 leave the level unchanged. A level moves by at most one per update.
- R8: Accuracy is high when useful_running*100 >= pct*issued_running, so equality counts as high. Prefetch rate is high when issued_running >= the prefetch threshold. Cache load is high when access_running >= the load threshold.
- R9: An interval is `interval_len_i` cycles long (a value of 0 or 1 closes an interval every cycle). Events in the closing cycle belong to the closing interval.
- R10: Levels and the valid strobe update at the second rising edge after the interval's final cycle. Levels change only when valid is 1, and valid is 1 for one cycle per interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_len_i | input | 16 | Sampling interval length in cycles |
| acc_pct_i | input | 7 | Accuracy threshold in percent |
| pf_thr_i | input | 17 | Threshold on running prefetch-issue value |
| llc_thr_i | input | 17 | Threshold on running shared-cache access value |
| pf_issue_i | input | 4 | Per-core prefetch issued this cycle |
| pf_useful_i | input | 4 | Per-core prefetch found useful this cycle |
| llc_access_i | input | 4 | Per-core shared-cache access this cycle |
| step_req_i | input | 8 | Per-core local step proposal, 2 bits each |
| level_o | output | 12 | Per-core aggressiveness level, 3 bits each |
| level_valid_o | output | 1 | One-cycle strobe marking an update of level_o |

## Verification
Call the last cycle of an interval T. Its events and the proposals sampled in T reach the running values at the edge that ends T. The levels and valid strobe change at the following edge, so they are visible from cycle T+2. The bench model follows the same register path: at each rising edge it first applies any update pending from the previous interval end, then folds in the events. The model is compared with the outputs at every falling edge, so a result arriving one cycle early or late shows up at once. The directed checks wait for the valid strobe and then read the levels in that same cycle, before the next edge can move them.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLD2 = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    OVR_PASS       = 2'd0,
    OVR_FORCE_DOWN = 2'd1,
    OVR_BLOCK_UP   = 2'd2
  } ovr_e;

  typedef struct packed {
    logic acc_hi;
    logic pf_hi;
    logic llc_hi;
  } cls_t;

  // Fixed override table on the three judgements
  function automatic ovr_e pick_override(cls_t c);
    ovr_e r;
    r = OVR_PASS;
    if (!c.acc_hi && c.pf_hi && c.llc_hi)      r = OVR_FORCE_DOWN;
    else if (c.acc_hi && c.pf_hi && c.llc_hi)  r = OVR_BLOCK_UP;
    else if (!c.acc_hi && c.pf_hi && !c.llc_hi) r = OVR_BLOCK_UP;
    return r;
  endfunction

endpackage

// File: rtl/gpc_interval_timer.sv
module gpc_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign tick_o = (cnt_nx >= {1'b0, len_i});

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_nx[CNT_W-1:0];
  end

  // R9: the cycle counter restarts after an interval end
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/gpc_core_monitor.sv
module gpc_core_monitor import gpc_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [2:0]       evt_i,   // 0 issue, 1 useful, 2 cache access
  input  logic [PCT_W-1:0] pct_i,
  input  logic [CNT_W:0]   pf_thr_i,
  input  logic [CNT_W:0]   llc_thr_i,
  output cls_t             cls_o
);
  localparam int SW = CNT_W + 1;
  localparam int MW = SW + PCT_W;

  logic [CNT_W-1:0] cnt_q  [3];
  logic [CNT_W-1:0] cnt_inc[3];
  logic [SW-1:0]    sm_q   [3];

  for (genvar k = 0; k < 3; k++) begin : g_evt
    assign cnt_inc[k] = (evt_i[k] && (cnt_q[k] != {CNT_W{1'b1}}))
                        ? cnt_q[k] + 1'b1 : cnt_q[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[k] <= '0;
        sm_q[k]  <= '0;
      end else if (tick_i) begin
        cnt_q[k] <= '0;
        sm_q[k]  <= (sm_q[k] >> 1) + SW'(cnt_inc[k]);
      end else begin
        cnt_q[k] <= cnt_inc[k];
      end
    end

    // R2: interval counts restart once folded in
    p_count_clear_r2: assert property (@(posedge clk) disable iff (rst)
      tick_i |=> (cnt_q[k] == '0));
  end

  logic [MW-1:0] acc_lhs, acc_rhs;
  assign acc_lhs = MW'(sm_q[1]) * MW'(100);
  assign acc_rhs = MW'(pct_i) * MW'(sm_q[0]);

  always_comb begin
    cls_o.acc_hi = (acc_lhs >= acc_rhs);
    cls_o.pf_hi  = (sm_q[0] >= pf_thr_i);
    cls_o.llc_hi = (sm_q[2] >= llc_thr_i);
  end

endmodule

// File: rtl/gpc_level_unit.sv
module gpc_level_unit import gpc_pkg::*; #(
  parameter int LVL_W   = 3,
  parameter int LVL_MIN = 1,
  parameter int LVL_MAX = 5,
  parameter int LVL_RST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic [1:0]       step_i,
  input  cls_t             cls_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] L_MIN = LVL_W'(LVL_MIN);
  localparam logic [LVL_W-1:0] L_MAX = LVL_W'(LVL_MAX);
  localparam logic [LVL_W-1:0] L_RST = LVL_W'(LVL_RST);

  ovr_e ovr;
  logic go_up, go_dn;
  logic [LVL_W-1:0] level_q;

  assign ovr = pick_override(cls_i);

  always_comb begin
    go_up = (step_i == STEP_UP);
    go_dn = (step_i == STEP_DOWN);
    case (ovr)
      OVR_FORCE_DOWN: begin go_up = 1'b0; go_dn = 1'b1; end
      OVR_BLOCK_UP:   go_up = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= L_RST;
    else if (upd_i) begin
      if (go_dn && (level_q > L_MIN))      level_q <= level_q - 1'b1;
      else if (go_up && (level_q < L_MAX)) level_q <= level_q + 1'b1;
    end
  end

  assign level_o = level_q;

  // R7: level stays in range
  p_level_range_r7: assert property (@(posedge clk) disable iff (rst)
    (level_q >= L_MIN) && (level_q <= L_MAX));

  // R7: at most one step per update
  p_one_step_r7: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |->
      ((level_q == $past(level_q) + 1'b1) || (level_q == $past(level_q) - 1'b1)));

  // R3: forced reduction
  p_force_down_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_i && (ovr == OVR_FORCE_DOWN)) |=>
      ((level_q == L_MIN) || (level_q == $past(level_q) - 1'b1)));

  // R4 and R5: no rise while blocked
  p_block_up_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_i && (ovr == OVR_BLOCK_UP)) |=> (level_q <= $past(level_q)));

endmodule

// File: rtl/gpc_aggr_override.sv
module gpc_aggr_override import gpc_pkg::*; #(
  parameter int NCORE   = 4,
  parameter int CNT_W   = 16,
  parameter int PCT_W   = 7,
  parameter int LVL_W   = 3,
  parameter int LVL_MIN = 1,
  parameter int LVL_MAX = 5,
  parameter int LVL_RST = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       interval_len_i,
  input  logic [PCT_W-1:0]       acc_pct_i,
  input  logic [CNT_W:0]         pf_thr_i,
  input  logic [CNT_W:0]         llc_thr_i,
  input  logic [NCORE-1:0]       pf_issue_i,
  input  logic [NCORE-1:0]       pf_useful_i,
  input  logic [NCORE-1:0]       llc_access_i,
  input  logic [2*NCORE-1:0]     step_req_i,
  output logic [NCORE*LVL_W-1:0] level_o,
  output logic                   level_valid_o
);
  logic tick, upd_q, valid_q;
  logic [1:0] prop_q [NCORE];
  cls_t       cls    [NCORE];

  gpc_interval_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .len_i(interval_len_i), .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      upd_q   <= tick;
      valid_q <= upd_q;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst)       prop_q[c] <= STEP_HOLD;
      else if (tick) prop_q[c] <= step_req_i[2*c +: 2];
    end

    gpc_core_monitor #(.CNT_W(CNT_W), .PCT_W(PCT_W)) i_mon (
      .clk(clk), .rst(rst), .tick_i(tick),
      .evt_i({llc_access_i[c], pf_useful_i[c], pf_issue_i[c]}),
      .pct_i(acc_pct_i), .pf_thr_i(pf_thr_i), .llc_thr_i(llc_thr_i),
      .cls_o(cls[c])
    );

    gpc_level_unit #(.LVL_W(LVL_W), .LVL_MIN(LVL_MIN), .LVL_MAX(LVL_MAX),
                     .LVL_RST(LVL_RST)) i_lvl (
      .clk(clk), .rst(rst), .upd_i(upd_q), .step_i(prop_q[c]),
      .cls_i(cls[c]), .level_o(level_o[LVL_W*c +: LVL_W])
    );
  end

  assign level_valid_o = valid_q;

  // R10: levels move only together with the strobe
  p_level_on_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (level_o != $past(level_o)) |-> level_valid_o);

  // R10: strobe follows an interval end by two edges
  p_valid_after_end_r10: assert property (@(posedge clk) disable iff (rst)
    level_valid_o |-> $past(upd_q));

endmodule

// File: tb/test_gpc_aggr_override.sv
module test_gpc_aggr_override;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] len = 16'd8;
  logic [6:0]  pct = 7'd50;
  logic [16:0] pf_thr = 17'd4;
  logic [16:0] llc_thr = 17'd4;
  logic [N-1:0] iss = '0, use_ = '0, acc = '0;
  logic [2*N-1:0] step = '0;
  logic [3*N-1:0] level;
  logic valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpc_aggr_override i_gpc_aggr_override (
    .clk(clk), .rst(rst), .interval_len_i(len), .acc_pct_i(pct),
    .pf_thr_i(pf_thr), .llc_thr_i(llc_thr), .pf_issue_i(iss),
    .pf_useful_i(use_), .llc_access_i(acc), .step_req_i(step),
    .level_o(level), .level_valid_o(valid)
  );

  // Behavioural reference model
  int m_tcnt, m_upd, m_valid;
  int m_lvl[N];
  int m_cnt[N][3];
  int m_sm[N][3];
  int m_prop[N];

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_tcnt = 0; m_upd = 0; m_valid = 0;
      for (int c = 0; c < N; c++) begin
        m_lvl[c] = 3; m_prop[c] = 0;
        for (int k = 0; k < 3; k++) begin m_cnt[c][k] = 0; m_sm[c][k] = 0; end
      end
    end else begin
      bit tk;
      m_valid = m_upd;
      if (m_upd) begin
        for (int c = 0; c < N; c++) begin
          bit ahi, phi, lhi, up, dn;
          ahi = (m_sm[c][1] * 100 >= int'(pct) * m_sm[c][0]);
          phi = (m_sm[c][0] >= int'(pf_thr));
          lhi = (m_sm[c][2] >= int'(llc_thr));
          up = (m_prop[c] == 1);
          dn = (m_prop[c] == 2);
          if (!ahi && phi && lhi) begin up = 0; dn = 1; end
          else if (phi && (ahi == lhi)) up = 0;
          if (dn && m_lvl[c] > 1) m_lvl[c]--;
          else if (up && m_lvl[c] < 5) m_lvl[c]++;
        end
      end
      tk = (m_tcnt + 1 >= int'(len));
      for (int c = 0; c < N; c++) begin
        int ev[3];
        ev[0] = iss[c]; ev[1] = use_[c]; ev[2] = acc[c];
        for (int k = 0; k < 3; k++) begin
          int inc;
          inc = m_cnt[c][k] + ev[k];
          if (inc > 65535) inc = 65535;
          if (tk) begin m_sm[c][k] = m_sm[c][k] / 2 + inc; m_cnt[c][k] = 0; end
          else m_cnt[c][k] = inc;
        end
        if (tk) m_prop[c] = int'(step[2*c +: 2]);
      end
      m_upd = tk;
      m_tcnt = tk ? 0 : m_tcnt + 1;
    end
  end

  // Every-cycle comparison against the model (R9, R10)
  always @(negedge clk) begin
    if (started && !done) begin
      n_tests++;
      if (int'(valid) != m_valid) begin
        n_fail++;
        $display("FAIL R10 valid: actual %0d expected %0d at %0t", valid, m_valid, $time);
      end
      for (int c = 0; c < N; c++) begin
        n_tests++;
        if (int'(level[3*c +: 3]) != m_lvl[c]) begin
          n_fail++;
          $display("FAIL R9 model level core%0d: actual %0d expected %0d at %0t",
                   c, level[3*c +: 3], m_lvl[c], $time);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_lv(input string req, input int a0, input int a1, input int a2, input int a3);
    chk({req, " core0"}, int'(level[2:0]),  a0);
    chk({req, " core1"}, int'(level[5:3]),  a1);
    chk({req, " core2"}, int'(level[8:6]),  a2);
    chk({req, " core3"}, int'(level[11:9]), a3);
  endtask

  task automatic wait_valid();
    int t;
    t = 0;
    @(negedge clk);
    while (!valid && t < 200) begin @(negedge clk); t++; end
    if (!valid) begin n_fail++; $display("FAIL R10 timeout: actual 0 expected 1"); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // Phase A: table cases and saturation
    iss  = 4'b0111; use_ = 4'b0010; acc = 4'b1011;
    step = {2'b01, 2'b01, 2'b01, 2'b01};
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(valid), 0);
    chk_lv("R1 reset level", 3, 3, 3, 3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid before update", int'(valid), 0);
    wait_valid();
    chk("R3 force down", int'(level[2:0]), 2);
    chk("R4 up blocked", int'(level[5:3]), 3);
    chk("R5 up blocked", int'(level[8:6]), 3);
    chk("R6 up passes", int'(level[11:9]), 4);
    wait_valid();
    wait_valid();
    chk("R7 floor", int'(level[2:0]), 1);
    chk("R7 ceiling", int'(level[11:9]), 5);
    step = {2'b10, 2'b00, 2'b10, 2'b01};
    wait_valid();
    chk_lv("R4 down passes / R5 hold", 1, 2, 3, 4);
    step = {2'b11, 2'b00, 2'b10, 2'b01};
    wait_valid();
    chk_lv("R6 hold code 11", 1, 1, 3, 4);

    // Phase B: smoothing makes the rate cross its threshold
    do_reset();
    pf_thr = 17'd10; llc_thr = 17'd0;
    iss = 4'b0011; use_ = 4'b0010; acc = 4'b0000;
    step = {2'b01, 2'b01, 2'b01, 2'b01};
    wait_valid();
    chk_lv("R2 first interval low rate", 4, 4, 4, 4);
    wait_valid();
    chk("R2 running value 12 forces down", int'(level[2:0]), 3);
    chk("R4 running value blocks up", int'(level[5:3]), 4);
    chk("R6 idle core passes", int'(level[11:9]), 5);

    // Phase C: accuracy equality and interval length
    do_reset();
    pct = 7'd100; pf_thr = 17'd4; llc_thr = 17'd0;
    iss = 4'b1100; use_ = 4'b0100; acc = 4'b0000;
    wait_valid();
    chk("R8 equal accuracy is high", int'(level[8:6]), 3);
    chk("R8 zero accuracy is low", int'(level[11:9]), 2);
    len = 16'd3;
    wait_valid();
    wait_valid();
    begin
      int gap;
      gap = 0;
      @(negedge clk); gap++;
      while (!valid && gap < 50) begin @(negedge clk); gap++; end
      chk("R9 interval length 3", gap, 3);
    end
    len = 16'd1;
    wait_valid();
    @(negedge clk);
    chk("R9 length 1 strobes every cycle", int'(valid), 1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule